// File: doc/BRIEF.md
# Two-Slot Word Accumulator Sequencer

This block is the control unit and main datapath of a small accumulator machine whose 40-bit memory words each carry two 20-bit instructions. It fetches a word over a synchronous memory port, executes the left instruction and then the right one, and moves on to the next word. Two registers are held inside: the accumulator (AC) and a multiplier/quotient register (MQ). Numbers are sign-magnitude with the sign in bit 39 and the magnitude in bits 38:0.

Loads, stores, add and subtract (plain and absolute-value forms), one-bit shifts, unconditional and sign-conditional jumps to either half of a word, and two stores that patch only the address field of a stored instruction are executed here. Patching a stored instruction lets a program rewrite its own operand addresses. Multiply and divide are passed to an external multicycle unit through a start/done handshake. Any opcode outside the defined set stops the machine.

Top module: `duo_seq_core`

## Requirements
- R1: While reset is held and in the first cycle after release, halt_o is low and the block requests a read (mem_rd_o high) at address START_ADDR (default 0). The left instruction of that word runs first.
- R2: Word layout: bits 39:32 hold the left opcode and 31:20 its address. Bits 19:12 hold the right opcode and 11:0 its address. After a left instruction that does not jump, the right one of the same word runs. After the right one, the word at the next address is fetched.
- R3: Data transfer opcodes: 0x01 AC=M(X), 0x02 AC=M(X) with the sign inverted, 0x03 AC=|M(X)|, 0x04 AC=-|M(X)|, 0x09 MQ=M(X), 0x0A AC=MQ, 0x21 writes AC to M(X).
- R4: Arithmetic opcodes: 0x05 adds M(X) to AC and 0x06 subtracts it. 0x07 adds |M(X)| and 0x08 subtracts |M(X)|. All use sign-magnitude rules. When the magnitudes are equal and the signs differ, the result is +0.
- R5: 0x14 shifts the AC magnitude left by one and 0x15 shifts it right by one. The sign is kept, and the magnitude bit shifted out is lost.
- R6: 0x0D jumps to the left instruction of word X. 0x0E jumps to the right instruction of word X, and the left instruction of X is skipped. The instruction after a taken jump in the same word does not run.
- R7: 0x0F (left target) and 0x10 (right target) jump only when AC bit 39 is 0. Otherwise execution continues as if no jump were present.
- R8: 0x12 replaces bits 31:20 of M(X) with AC bits 11:0, and 0x13 replaces bits 11:0 of M(X) with them. All other bits are kept. The write to X happens in the cycle right after the read of X.
- R9: For 0x0B (multiply, mdu_op_o=0) and 0x0C (divide, mdu_op_o=1), M(X) is read and then mdu_start_o pulses for one cycle. During the pulse mdu_ac_o, mdu_mq_o and mdu_opnd_o carry AC, MQ and M(X). The block waits for mdu_done_i, then loads AC and MQ from mdu_ac_i and mdu_mq_i.
- R10: An undefined opcode sets halt_o, which stays high until reset. While halted there are no memory reads, no memory writes and no start pulses, and the other half of the word does not run.
- R11: mem_rd_o and mem_wr_o are never high in the same cycle, and mdu_start_o is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mem_addr_o | output | 12 | Memory word address |
| mem_rd_o | output | 1 | Read request; data returns on mem_rdata_i one cycle later |
| mem_wr_o | output | 1 | Write request for mem_wdata_o at mem_addr_o |
| mem_wdata_o | output | 40 | Write data |
| mem_rdata_i | input | 40 | Read data |
| mdu_start_o | output | 1 | One-cycle start to the multiply/divide unit |
| mdu_op_o | output | 1 | 0 multiply, 1 divide |
| mdu_ac_o | output | 40 | Current AC |
| mdu_mq_o | output | 40 | Current MQ |
| mdu_opnd_o | output | 40 | Memory operand |
| mdu_done_i | input | 1 | Unit finished; results valid this cycle |
| mdu_ac_i | input | 40 | New AC from the unit |
| mdu_mq_i | input | 40 | New MQ from the unit |
| halt_o | output | 1 | Machine stopped on an undefined opcode |

## Verification
AC and MQ are not visible at the ports. A corrupted value in either one therefore shows up only at the next store, either as a wrong mem_wdata_o or as a wrong patched field. Each test program ends with a store soon after the operation under test, so such an error appears within a few instructions. A wrong half flag or program counter shows up sooner: within about three cycles it puts a fetch or operand read at an unexpected mem_addr_o, and it leaves a sentinel word unwritten or writes one that should stay untouched. A wrong halt decision shows up as halt_o changing, or as memory traffic that continues after an undefined opcode.

// File: rtl/duo_seq_pkg.sv
`timescale 1ns/1ps
package duo_seq_pkg;
    localparam int WORD_W = 40;
    localparam int HALF_W = WORD_W / 2;
    localparam int OP_W   = 8;
    localparam int ADDR_W = HALF_W - OP_W;
    localparam int MAG_W  = WORD_W - 1;
    localparam int SIGN_B = WORD_W - 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [MAG_W-1:0]  mag_t;
    typedef logic [OP_W-1:0]   op_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam op_t OP_LD    = 8'h01;
    localparam op_t OP_LDN   = 8'h02;
    localparam op_t OP_LDA   = 8'h03;
    localparam op_t OP_LDNA  = 8'h04;
    localparam op_t OP_ADD   = 8'h05;
    localparam op_t OP_SUB   = 8'h06;
    localparam op_t OP_ADDA  = 8'h07;
    localparam op_t OP_SUBA  = 8'h08;
    localparam op_t OP_LDMQM = 8'h09;
    localparam op_t OP_LDMQ  = 8'h0A;
    localparam op_t OP_MUL   = 8'h0B;
    localparam op_t OP_DIV   = 8'h0C;
    localparam op_t OP_JL    = 8'h0D;
    localparam op_t OP_JR    = 8'h0E;
    localparam op_t OP_JPL   = 8'h0F;
    localparam op_t OP_JPR   = 8'h10;
    localparam op_t OP_PATL  = 8'h12;
    localparam op_t OP_PATR  = 8'h13;
    localparam op_t OP_LSH   = 8'h14;
    localparam op_t OP_RSH   = 8'h15;
    localparam op_t OP_ST    = 8'h21;

    typedef enum logic [2:0] {
        ST_FETCH, ST_LATCH, ST_DECODE, ST_OPWAIT, ST_MSTART, ST_MWAIT, ST_HALT
    } state_e;

    typedef struct packed {
        state_e st;
        addr_t  pc;
        logic   half;
        word_t  ir;
        word_t  ac;
        word_t  mq;
        word_t  opnd;
        logic   halt;
    } core_t;
endpackage

// File: rtl/duo_seq_halfpick.sv
`timescale 1ns/1ps
module duo_seq_halfpick
    import duo_seq_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic              right_i,
    output logic [OP_W-1:0]   op_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic [HALF_W-1:0] slot;

    always_comb begin
        slot   = right_i ? word_i[HALF_W-1:0] : word_i[WORD_W-1:HALF_W];
        op_o   = slot[HALF_W-1:ADDR_W];
        addr_o = slot[ADDR_W-1:0];
    end
endmodule

// File: rtl/duo_seq_smalu.sv
`timescale 1ns/1ps
module duo_seq_smalu
    import duo_seq_pkg::*;
(
    input  logic [OP_W-1:0]   op_i,
    input  logic [WORD_W-1:0] ac_i,
    input  logic [WORD_W-1:0] m_i,
    output logic [WORD_W-1:0] res_o
);
    function automatic word_t sm_add(input word_t a, input word_t b);
        mag_t ma;
        mag_t mb;
        ma = a[MAG_W-1:0];
        mb = b[MAG_W-1:0];
        if (a[SIGN_B] == b[SIGN_B])
            sm_add = {a[SIGN_B], mag_t'(ma + mb)};
        else if (ma > mb)
            sm_add = {a[SIGN_B], mag_t'(ma - mb)};
        else if (ma == mb)
            sm_add = '0;
        else
            sm_add = {b[SIGN_B], mag_t'(mb - ma)};
    endfunction

    mag_t m_mag;
    mag_t a_mag;

    always_comb begin
        m_mag = m_i[MAG_W-1:0];
        a_mag = ac_i[MAG_W-1:0];
        res_o = ac_i;
        case (op_i)
            OP_LD:   res_o = m_i;
            OP_LDN:  res_o = {~m_i[SIGN_B], m_mag};
            OP_LDA:  res_o = {1'b0, m_mag};
            OP_LDNA: res_o = {1'b1, m_mag};
            OP_ADD:  res_o = sm_add(ac_i, m_i);
            OP_SUB:  res_o = sm_add(ac_i, {~m_i[SIGN_B], m_mag});
            OP_ADDA: res_o = sm_add(ac_i, {1'b0, m_mag});
            OP_SUBA: res_o = sm_add(ac_i, {1'b1, m_mag});
            OP_LSH:  res_o = {ac_i[SIGN_B], a_mag[MAG_W-2:0], 1'b0};
            OP_RSH:  res_o = {ac_i[SIGN_B], 1'b0, a_mag[MAG_W-1:1]};
            default: res_o = ac_i;
        endcase
    end
endmodule

// File: rtl/duo_seq_fieldpatch.sv
`timescale 1ns/1ps
module duo_seq_fieldpatch
    import duo_seq_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [WORD_W-1:0] ac_i,
    input  logic              right_i,
    output logic [WORD_W-1:0] word_o
);
    localparam int LEFT_LSB = HALF_W;

    always_comb begin
        word_o = word_i;
        if (right_i)
            word_o[ADDR_W-1:0] = ac_i[ADDR_W-1:0];
        else
            word_o[LEFT_LSB +: ADDR_W] = ac_i[ADDR_W-1:0];
    end
endmodule

// File: rtl/duo_seq_core.sv
`timescale 1ns/1ps
module duo_seq_core
    import duo_seq_pkg::*;
#(
    parameter int START_ADDR = 0
)(
    input  logic              clk_i,
    input  logic              rst_ni,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              mdu_start_o,
    output logic              mdu_op_o,
    output logic [WORD_W-1:0] mdu_ac_o,
    output logic [WORD_W-1:0] mdu_mq_o,
    output logic [WORD_W-1:0] mdu_opnd_o,
    input  logic              mdu_done_i,
    input  logic [WORD_W-1:0] mdu_ac_i,
    input  logic [WORD_W-1:0] mdu_mq_i,
    output logic              halt_o
);
    core_t r_q;
    core_t r_d;

    logic [OP_W-1:0]   cur_op;
    logic [ADDR_W-1:0] cur_addr;
    logic [WORD_W-1:0] alu_res;
    logic [WORD_W-1:0] patched;
    logic              adv;
    logic              jmp;
    logic              jmp_right;

    duo_seq_halfpick u_pick (
        .word_i  (r_q.ir),
        .right_i (r_q.half),
        .op_o    (cur_op),
        .addr_o  (cur_addr)
    );

    duo_seq_smalu u_alu (
        .op_i  (cur_op),
        .ac_i  (r_q.ac),
        .m_i   (mem_rdata_i),
        .res_o (alu_res)
    );

    duo_seq_fieldpatch u_patch (
        .word_i  (mem_rdata_i),
        .ac_i    (r_q.ac),
        .right_i (cur_op == OP_PATR),
        .word_o  (patched)
    );

    always_comb begin
        r_d         = r_q;
        mem_addr_o  = r_q.pc;
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        mem_wdata_o = r_q.ac;
        mdu_start_o = 1'b0;
        adv         = 1'b0;
        jmp         = 1'b0;
        jmp_right   = 1'b0;

        case (r_q.st)
            ST_FETCH: begin
                mem_rd_o = 1'b1;
                r_d.st   = ST_LATCH;
            end
            ST_LATCH: begin
                r_d.ir = mem_rdata_i;
                r_d.st = ST_DECODE;
            end
            ST_DECODE: begin
                mem_addr_o = cur_addr;
                case (cur_op)
                    OP_LD, OP_LDN, OP_LDA, OP_LDNA,
                    OP_ADD, OP_SUB, OP_ADDA, OP_SUBA,
                    OP_LDMQM, OP_MUL, OP_DIV, OP_PATL, OP_PATR: begin
                        mem_rd_o = 1'b1;
                        r_d.st   = ST_OPWAIT;
                    end
                    OP_ST: begin
                        mem_wr_o = 1'b1;
                        adv      = 1'b1;
                    end
                    OP_LDMQ: begin
                        r_d.ac = r_q.mq;
                        adv    = 1'b1;
                    end
                    OP_LSH, OP_RSH: begin
                        r_d.ac = alu_res;
                        adv    = 1'b1;
                    end
                    OP_JL, OP_JR: begin
                        jmp       = 1'b1;
                        jmp_right = (cur_op == OP_JR);
                    end
                    OP_JPL, OP_JPR: begin
                        if (!r_q.ac[SIGN_B]) begin
                            jmp       = 1'b1;
                            jmp_right = (cur_op == OP_JPR);
                        end else begin
                            adv = 1'b1;
                        end
                    end
                    default: begin
                        r_d.halt = 1'b1;
                        r_d.st   = ST_HALT;
                    end
                endcase
            end
            ST_OPWAIT: begin
                mem_addr_o = cur_addr;
                case (cur_op)
                    OP_LDMQM: begin
                        r_d.mq = mem_rdata_i;
                        adv    = 1'b1;
                    end
                    OP_MUL, OP_DIV: begin
                        r_d.opnd = mem_rdata_i;
                        r_d.st   = ST_MSTART;
                    end
                    OP_PATL, OP_PATR: begin
                        mem_wr_o    = 1'b1;
                        mem_wdata_o = patched;
                        adv         = 1'b1;
                    end
                    default: begin
                        r_d.ac = alu_res;
                        adv    = 1'b1;
                    end
                endcase
            end
            ST_MSTART: begin
                mdu_start_o = 1'b1;
                r_d.st      = ST_MWAIT;
            end
            ST_MWAIT: begin
                if (mdu_done_i) begin
                    r_d.ac = mdu_ac_i;
                    r_d.mq = mdu_mq_i;
                    adv    = 1'b1;
                end
            end
            default: begin
                r_d.st = ST_HALT;
            end
        endcase

        if (jmp) begin
            r_d.pc   = cur_addr;
            r_d.half = jmp_right;
            r_d.st   = ST_FETCH;
        end else if (adv) begin
            if (!r_q.half) begin
                r_d.half = 1'b1;
                r_d.st   = ST_DECODE;
            end else begin
                r_d.half = 1'b0;
                r_d.pc   = r_q.pc + addr_t'(1);
                r_d.st   = ST_FETCH;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q.st   <= ST_FETCH;
            r_q.pc   <= addr_t'(START_ADDR);
            r_q.half <= 1'b0;
            r_q.ir   <= '0;
            r_q.ac   <= '0;
            r_q.mq   <= '0;
            r_q.opnd <= '0;
            r_q.halt <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mdu_op_o   = (cur_op == OP_DIV);
    assign mdu_ac_o   = r_q.ac;
    assign mdu_mq_o   = r_q.mq;
    assign mdu_opnd_o = r_q.opnd;
    assign halt_o     = r_q.halt;
endmodule

// File: rtl/duo_seq_chk.sv
`timescale 1ns/1ps
module duo_seq_chk
    import duo_seq_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_rd_o,
    input logic              mem_wr_o,
    input logic              mdu_start_o,
    input logic              halt_o
);
    a_r11_rd_wr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(mem_rd_o && mem_wr_o));

    a_r11_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mdu_start_o |=> !mdu_start_o);

    a_r10_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halt_o |=> halt_o);

    a_r10_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halt_o |-> (!mem_rd_o && !mem_wr_o && !mdu_start_o));

    a_r9_start_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mdu_start_o |-> $past(mem_rd_o, 2));

    a_r8_patch_same_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_wr_o && $past(mem_rd_o)) |-> (mem_addr_o == $past(mem_addr_o)));
endmodule

bind duo_seq_core duo_seq_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mdu_start_o (mdu_start_o),
    .halt_o      (halt_o)
);

// File: tb/duo_seq_core_tb.sv
`timescale 1ns/1ps
module duo_seq_core_tb;
    localparam logic [39:0] SENT = 40'hEE_EEEE_EEEE;
    localparam logic [7:0] LD = 8'h01, LDN = 8'h02, LDA = 8'h03, LDNA = 8'h04;
    localparam logic [7:0] ADD = 8'h05, SUB = 8'h06, ADDA = 8'h07, SUBA = 8'h08;
    localparam logic [7:0] LDMQM = 8'h09, LDMQ = 8'h0A, MUL = 8'h0B, DIV = 8'h0C;
    localparam logic [7:0] JL = 8'h0D, JR = 8'h0E, JPL = 8'h0F, JPR = 8'h10;
    localparam logic [7:0] PATL = 8'h12, PATR = 8'h13, LSH = 8'h14, RSH = 8'h15, ST = 8'h21;
    localparam logic [7:0] BAD = 8'h00;

    // op1, op2, M(10), M(11), expected M(12)
    localparam int NV = 13;
    localparam logic [135:0] VEC [0:NV-1] = '{
        {LD,   ADD,  40'h00_0000_0005, 40'h00_0000_0003, 40'h00_0000_0008}, // R4
        {LD,   ADD,  40'h00_0000_0005, 40'h80_0000_0003, 40'h00_0000_0002}, // R4
        {LD,   ADD,  40'h00_0000_0003, 40'h80_0000_0005, 40'h80_0000_0002}, // R4
        {LD,   SUB,  40'h00_0000_0005, 40'h00_0000_0005, 40'h00_0000_0000}, // R4 +0
        {LD,   SUB,  40'h80_0000_0004, 40'h00_0000_0006, 40'h80_0000_000A}, // R4
        {LD,   ADDA, 40'h80_0000_0004, 40'h80_0000_0006, 40'h00_0000_0002}, // R4
        {LD,   SUBA, 40'h00_0000_0004, 40'h80_0000_0006, 40'h80_0000_0002}, // R4
        {LDN,  LSH,  40'h00_0000_0007, 40'h00_0000_0000, 40'h80_0000_000E}, // R3 R5
        {LDA,  RSH,  40'h80_0000_0009, 40'h00_0000_0000, 40'h00_0000_0004}, // R3 R5
        {LDNA, ADD,  40'h00_0000_0009, 40'h00_0000_0000, 40'h80_0000_0009}, // R3
        {LDMQM,LDMQ, 40'h00_0000_000B, 40'h00_0000_0000, 40'h00_0000_000B}, // R3
        {LD,   LSH,  40'h40_0000_0001, 40'h00_0000_0000, 40'h00_0000_0002}, // R5 lost bit
        {LD,   RSH,  40'h80_0000_0003, 40'h00_0000_0000, 40'h80_0000_0001}  // R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [39:0] mem_wdata, mem_rdata;
    logic        mdu_start, mdu_op, mdu_done;
    logic [39:0] mdu_ac, mdu_mq, mdu_opnd, mdu_ac_res, mdu_mq_res;
    logic        halt;

    logic [39:0] mem [0:63];
    logic        ld_en = 1'b0, ld_clr = 1'b0;
    logic [5:0]  ld_a = '0;
    logic [39:0] ld_d = '0;
    logic [39:0] lat_a, lat_q, lat_o;
    int          mcnt;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, n_start = 0, n_overlap = 0, n_quiet = 0;
    int rd50 = -1, wr50 = -1;
    logic [39:0] s_ac, s_mq, s_opnd;
    logic        s_op;

    always #2.5 clk = ~clk;

    duo_seq_core u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .mdu_start_o(mdu_start), .mdu_op_o(mdu_op),
        .mdu_ac_o(mdu_ac), .mdu_mq_o(mdu_mq), .mdu_opnd_o(mdu_opnd),
        .mdu_done_i(mdu_done), .mdu_ac_i(mdu_ac_res), .mdu_mq_i(mdu_mq_res),
        .halt_o(halt)
    );

    // memory model, one-cycle read latency
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ld_clr) begin
            for (int i = 0; i < 64; i++) mem[i] <= SENT;
        end else if (ld_en) begin
            mem[ld_a] <= ld_d;
        end else if (mem_wr) begin
            mem[mem_addr[5:0]] <= mem_wdata;
        end
        if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];
    end

    // multiply/divide unit model: done three cycles after start
    always @(posedge clk) begin
        if (!rst_n) begin
            mcnt <= 0;
            mdu_done <= 1'b0;
        end else begin
            mdu_done <= 1'b0;
            if (mdu_start) begin
                mcnt <= 3;
                lat_a <= mdu_ac; lat_q <= mdu_mq; lat_o <= mdu_opnd;
            end else if (mcnt != 0) begin
                mcnt <= mcnt - 1;
                if (mcnt == 1) mdu_done <= 1'b1;
            end
        end
    end
    assign mdu_ac_res = lat_o + 40'd100;
    assign mdu_mq_res = lat_a + lat_q;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd && mem_wr) n_overlap++;
            if (halt && (mem_rd || mem_wr || mdu_start)) n_quiet++;
            if (mem_rd && mem_addr == 12'd50) rd50 = cyc;
            if (mem_wr && mem_addr == 12'd50) wr50 = cyc;
            if (mdu_start) begin
                if (n_start == 0) begin
                    s_ac = mdu_ac; s_mq = mdu_mq; s_opnd = mdu_opnd; s_op = mdu_op;
                end else begin
                    s_op = mdu_op;
                end
                n_start++;
            end
        end
    end

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [39:0] w(input logic [7:0] o1, input logic [11:0] a1,
                                      input logic [7:0] o2, input logic [11:0] a2);
        return {o1, a1, o2, a2};
    endfunction

    task automatic put(input int a, input logic [39:0] d);
        ld_en = 1'b1; ld_a = 6'(a); ld_d = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic begin_prog();
        @(negedge clk);
        rst_n = 1'b0;
        ld_clr = 1'b1;
        @(negedge clk);
        ld_clr = 1'b0;
        n_start = 0; rd50 = -1; wr50 = -1;
    endtask

    task automatic run_prog(input string req);
        rst_n = 1'b1;
        for (int i = 0; i < 2000 && !halt; i++) @(negedge clk);
        chk({req, " reached halt"}, 40'(halt), 40'd1);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state and first fetch
        begin_prog();
        put(0, w(LD, 12'd10, ST, 12'd12));
        put(1, w(BAD, 12'd0, BAD, 12'd0));
        put(10, 40'h00_0000_0033);
        chk("R1 halt low in reset", 40'(halt), 40'd0);
        rst_n = 1'b1;
        #1;
        chk("R1 first read", 40'(mem_rd), 40'd1);
        chk("R1 first address", 40'(mem_addr), 40'd0);
        chk("R1 halt low after release", 40'(halt), 40'd0);
        run_prog("R1");
        chk("R1 R2 left then right", mem[12], 40'h00_0000_0033);

        // R2 R3 R4 R5: vector table
        for (int v = 0; v < NV; v++) begin
            begin_prog();
            put(0, w(VEC[v][135:128], 12'd10, VEC[v][127:120], 12'd11));
            put(1, w(ST, 12'd12, BAD, 12'd0));
            put(10, VEC[v][119:80]);
            put(11, VEC[v][79:40]);
            run_prog("R2");
            chk($sformatf("R3/R4/R5 vector %0d", v), mem[12], VEC[v][39:0]);
        end

        // R6: unconditional jumps to right and left halves
        begin_prog();
        put(0, w(LD, 12'd30, JR, 12'd3));
        put(1, w(ST, 12'd20, BAD, 12'd0));
        put(3, w(LD, 12'd31, ST, 12'd21));
        put(4, w(JL, 12'd6, ST, 12'd22));
        put(6, w(ST, 12'd23, BAD, 12'd0));
        put(30, 40'h00_0000_0007);
        put(31, 40'h00_0000_0009);
        run_prog("R6");
        chk("R6 right target skips left", mem[21], 40'h00_0000_0007);
        chk("R6 word after jump untouched", mem[20], SENT);
        chk("R6 left jump target", mem[23], 40'h00_0000_0007);
        chk("R6 slot after taken jump", mem[22], SENT);

        // R7: conditional jumps
        begin_prog();
        put(0, w(LD, 12'd30, JPR, 12'd5));
        put(5, w(ST, 12'd40, ST, 12'd41));
        put(6, w(LDN, 12'd30, JPL, 12'd8));
        put(7, w(ST, 12'd42, BAD, 12'd0));
        put(8, w(ST, 12'd43, BAD, 12'd0));
        put(30, 40'h00_0000_0007);
        run_prog("R7");
        chk("R7 taken right skips left", mem[40], SENT);
        chk("R7 taken on nonnegative", mem[41], 40'h00_0000_0007);
        chk("R7 not taken falls through", mem[42], 40'h80_0000_0007);
        chk("R7 not taken target idle", mem[43], SENT);

        // R8: address-field patching
        begin_prog();
        put(0, w(LD, 12'd30, PATL, 12'd50));
        put(1, w(PATR, 12'd51, BAD, 12'd0));
        put(30, 40'h0F_FFFF_FABC);
        put(50, 40'h12_3456_789A);
        put(51, 40'h12_3456_789A);
        run_prog("R8");
        chk("R8 left field patched", mem[50], 40'h12_ABC6_789A);
        chk("R8 right field patched", mem[51], 40'h12_3456_7ABC);
        chk("R8 write one cycle after read", 40'(wr50 - rd50), 40'd1);

        // R8: patched instruction is then executed
        begin_prog();
        put(0, w(LD, 12'd30, PATR, 12'd1));
        put(1, w(LD, 12'd31, ST, 12'd63));
        put(2, w(BAD, 12'd0, BAD, 12'd0));
        put(30, 40'h00_0000_002C);
        put(31, 40'h00_0000_0009);
        run_prog("R8");
        chk("R8 self-modified store target", mem[44], 40'h00_0000_0009);
        chk("R8 old store target idle", mem[63], SENT);

        // R9: multiply and divide handshake
        begin_prog();
        put(0, w(LDMQM, 12'd30, LD, 12'd31));
        put(1, w(MUL, 12'd32, ST, 12'd33));
        put(2, w(LDMQ, 12'd0, ST, 12'd34));
        put(3, w(DIV, 12'd32, ST, 12'd35));
        put(4, w(BAD, 12'd0, BAD, 12'd0));
        put(30, 40'h00_0000_0006);
        put(31, 40'h00_0000_0005);
        put(32, 40'h00_0000_0007);
        run_prog("R9");
        chk("R9 AC at start", s_ac, 40'h00_0000_0005);
        chk("R9 MQ at start", s_mq, 40'h00_0000_0006);
        chk("R9 operand at start", s_opnd, 40'h00_0000_0007);
        chk("R9 start count", 40'(n_start), 40'd2);
        chk("R9 divide select", 40'(s_op), 40'd1);
        chk("R9 AC from unit", mem[33], 40'd107);
        chk("R9 MQ from unit", mem[34], 40'd11);
        chk("R9 AC after divide", mem[35], 40'd107);

        // R10: undefined opcode in the left slot
        begin_prog();
        put(0, w(8'h3F, 12'd0, ST, 12'd37));
        run_prog("R10");
        for (int i = 0; i < 20; i++) @(negedge clk);
        chk("R10 halt held", 40'(halt), 40'd1);
        chk("R10 right slot not run", mem[37], SENT);
        chk("R10 no traffic while halted", 40'(n_quiet), 40'd0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears halt", 40'(halt), 40'd0);

        chk("R11 no read and write together", 40'(n_overlap), 40'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule